// File: doc/BRIEF.md
# Register Access Error Status Monitor

This block sits beside a serial-interface register file and watches every write request that reaches it. Each write address is classified through a small parameterised lookup table as writable, read-only, factory-test, reserved or nonexistent. Illegal writes are recorded as sticky flags in an 8-bit status register, and so is a pulse from an asynchronous FIFO that signals an overflow. That pulse arrives already synchronised to the register clock.

Software reads the status register through a dedicated read strobe. The read returns the flags as they stood before the strobe's clock edge, and all flags clear at that edge. An event that lands in the same cycle as the read is not lost: it is kept for the following read. A write that targets a read-only register sets two flags, a specific one and a general bad-address one.

Default address map, which the parameters can change: 0x00–0x07 and 0x0A–0x0B are writable, 0x08–0x09 are factory-test, 0x0C and 0x0F are reserved, 0x0D (the status register) and 0x0E are read-only, and 0x10–0xFF do not exist.

Top module: `reg_err_monitor`

## Requirements
- R1: After a synchronous reset, every flag is 0 and `rd_data` is 0x00.
- R2: Status bits 7, 6, 1 and 0 always read 0.
- R3: A one-cycle `fifo_ovf` pulse sets status bit 5.
- R4: A write to a read-only address (0x0E by default) sets both bit 4 and bit 2.
- R5: A write to a factory-test address (0x08 or 0x09 by default) sets bit 3 only.
- R6: A write to a reserved address (0x0C, 0x0F) or to a nonexistent address (0x10 and above) sets bit 2 only.
- R7: A write to the status address 0x0D is treated as a read-only write and sets bits 4 and 2.
- R8: Writes to writable addresses (0x00–0x07, 0x0A, 0x0B) leave every flag unchanged.
- R9: A set flag stays set, through idle cycles and harmless writes, until a status read or a reset.
- R10: When `stat_rd` is sampled high, `rd_data` shows the flag value at that edge, starting from the following cycle. All flags clear at the same edge. `rd_data` holds its value until the next read.
- R11: If an event and a status read fall in the same cycle, the read returns the old value and the new event's flag is set for the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write request strobe |
| wr_addr | input | ADDR_W (8) | Address of the write request |
| fifo_ovf | input | 1 | Synchronised single-cycle FIFO overflow pulse |
| stat_rd | input | 1 | Status register read strobe |
| rd_data | output | STAT_W (8) | Registered status read data |

## Verification
The hardest case to reach is an error event that lands in exactly the cycle of a status read, so that the clear and the set compete at one edge. The bench drives inputs on the falling edge, cycle by cycle. This lets it put a FIFO pulse or a bad write on the same edge as `stat_rd`. It then issues a second read back to back and checks that the first read returns the old value and the second returns the new flag. Stickiness is exercised by leaving idle cycles and writable-address writes between the event and the read.

// File: rtl/regerr_pkg.sv
package regerr_pkg;

  localparam int CLS_W    = 3;
  localparam int FLAG_NUM = 4;
  localparam int FLAG_LSB = 2;

  // flag indices inside the flag bank; status bit = FLAG_LSB + index
  localparam int FL_ADDR = 0;
  localparam int FL_TEST = 1;
  localparam int FL_RO   = 2;
  localparam int FL_FIFO = 3;

  typedef enum logic [CLS_W-1:0] {
    ACC_RW   = 3'd0,
    ACC_RO   = 3'd1,
    ACC_TEST = 3'd2,
    ACC_RSVD = 3'd3,
    ACC_NONE = 3'd4
  } acc_class_e;

  localparam int DEF_DEPTH = 16;

  function automatic logic [CLS_W*DEF_DEPTH-1:0] default_map();
    logic [CLS_W*DEF_DEPTH-1:0] m;
    m = '0;
    for (int i = 0; i < DEF_DEPTH; i++) begin
      acc_class_e c;
      if (i == 8 || i == 9)        c = ACC_TEST;
      else if (i == 12 || i == 15) c = ACC_RSVD;
      else if (i == 13 || i == 14) c = ACC_RO;
      else                         c = ACC_RW;
      m[i*CLS_W +: CLS_W] = c;
    end
    return m;
  endfunction

endpackage

// File: rtl/regerr_addr_class.sv
module regerr_addr_class
  import regerr_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int MAP_DEPTH = DEF_DEPTH,
  parameter logic [ADDR_W-1:0] STATUS_ADDR = 8'h0D,
  parameter logic [CLS_W*MAP_DEPTH-1:0] CLASS_MAP = default_map()
) (
  input  logic [ADDR_W-1:0] addr,
  output acc_class_e        cls
);

  logic [CLS_W-1:0] code;
  logic             hit;

  always_comb begin
    code = '0;
    hit  = 1'b0;
    for (int i = 0; i < MAP_DEPTH; i++) begin
      if (addr == ADDR_W'(i)) begin
        code = CLASS_MAP[i*CLS_W +: CLS_W];
        hit  = 1'b1;
      end
    end
  end

  always_comb begin
    if (addr == STATUS_ADDR) begin
      cls = ACC_RO;
    end else if (!hit) begin
      cls = ACC_NONE;
    end else begin
      case (code)
        3'd0:    cls = ACC_RW;
        3'd1:    cls = ACC_RO;
        3'd2:    cls = ACC_TEST;
        3'd3:    cls = ACC_RSVD;
        default: cls = ACC_NONE;
      endcase
    end
  end

endmodule

// File: rtl/regerr_evt_decode.sv
module regerr_evt_decode
  import regerr_pkg::*;
(
  input  logic                wr_en,
  input  acc_class_e          cls,
  input  logic                fifo_ovf,
  output logic [FLAG_NUM-1:0] set_vec
);

  always_comb begin
    set_vec = '0;
    set_vec[FL_FIFO] = fifo_ovf;
    if (wr_en) begin
      case (cls)
        ACC_RO: begin
          set_vec[FL_RO]   = 1'b1;
          set_vec[FL_ADDR] = 1'b1;
        end
        ACC_TEST: set_vec[FL_TEST] = 1'b1;
        ACC_RSVD, ACC_NONE: set_vec[FL_ADDR] = 1'b1;
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/regerr_flag_bank.sv
module regerr_flag_bank #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_i,
  input  logic         clr_i,
  output logic [N-1:0] flag_q
);

  for (genvar i = 0; i < N; i++) begin : g_flag
    logic bit_q;

    always_ff @(posedge clk) begin
      if (rst) bit_q <= 1'b0;
      else     bit_q <= set_i[i] | (bit_q & ~clr_i);
    end

    assign flag_q[i] = bit_q;

    // R9
    sticky_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (bit_q && !clr_i) |=> bit_q);

    // R10
    read_clear_chk: assert property (@(posedge clk) disable iff (rst)
      (clr_i && !set_i[i]) |=> !bit_q);

    // R11
    keep_new_chk: assert property (@(posedge clk) disable iff (rst)
      (clr_i && set_i[i]) |=> bit_q);
  end

endmodule

// File: rtl/reg_err_monitor.sv
module reg_err_monitor
  import regerr_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int STAT_W    = 8,
  parameter int MAP_DEPTH = DEF_DEPTH,
  parameter logic [ADDR_W-1:0] STATUS_ADDR = 8'h0D,
  parameter logic [CLS_W*MAP_DEPTH-1:0] CLASS_MAP = default_map()
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic              fifo_ovf,
  input  logic              stat_rd,
  output logic [STAT_W-1:0] rd_data
);

  localparam int FLAG_MSB = FLAG_LSB + FLAG_NUM - 1;

  acc_class_e          cls;
  logic [FLAG_NUM-1:0] set_vec;
  logic [FLAG_NUM-1:0] flags_q;
  logic [STAT_W-1:0]   status_w;

  regerr_addr_class #(
    .ADDR_W      (ADDR_W),
    .MAP_DEPTH   (MAP_DEPTH),
    .STATUS_ADDR (STATUS_ADDR),
    .CLASS_MAP   (CLASS_MAP)
  ) u_class (
    .addr (wr_addr),
    .cls  (cls)
  );

  regerr_evt_decode u_dec (
    .wr_en    (wr_en),
    .cls      (cls),
    .fifo_ovf (fifo_ovf),
    .set_vec  (set_vec)
  );

  regerr_flag_bank #(.N(FLAG_NUM)) u_bank (
    .clk    (clk),
    .rst    (rst),
    .set_i  (set_vec),
    .clr_i  (stat_rd),
    .flag_q (flags_q)
  );

  for (genvar b = 0; b < STAT_W; b++) begin : g_stat
    if (b >= FLAG_LSB && b <= FLAG_MSB) begin : g_live
      assign status_w[b] = flags_q[b-FLAG_LSB];
    end else begin : g_zero
      assign status_w[b] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          rd_data <= '0;
    else if (stat_rd) rd_data <= status_w;
  end

  // R3
  fifo_set_chk: assert property (@(posedge clk) disable iff (rst)
    fifo_ovf |=> flags_q[FL_FIFO]);

  // R4
  ro_pair_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && cls == ACC_RO) |=> (flags_q[FL_RO] && flags_q[FL_ADDR]));

  // R8
  rw_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && cls == ACC_RW && !fifo_ovf && !stat_rd) |=> (flags_q == $past(flags_q)));

  // R10
  read_old_chk: assert property (@(posedge clk) disable iff (rst)
    stat_rd |=> (rd_data == $past(status_w)));

  // R10
  rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !stat_rd |=> $stable(rd_data));

endmodule

// File: tb/sim_reg_err_monitor.sv
`timescale 1ns/1ps
module sim_reg_err_monitor;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [7:0] wr_addr = '0;
  logic       fifo_ovf = 1'b0;
  logic       stat_rd = 1'b0;
  logic [7:0] rd_data;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  typedef struct {
    logic [7:0] val;
    string      tag;
  } exp_t;

  exp_t       sbq[$];
  logic [7:0] model = '0;
  logic [7:0] last_rd = '0;
  logic       pend = 1'b0;

  always #2.5 clk = ~clk;

  reg_err_monitor u0 (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .fifo_ovf (fifo_ovf),
    .stat_rd  (stat_rd),
    .rd_data  (rd_data)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual=0x%02h expected=0x%02h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] setbits(input logic w, input logic [7:0] a, input logic o);
    logic [7:0] s;
    s = o ? 8'h20 : 8'h00;
    if (w) begin
      if (a == 8'h0D || a == 8'h0E)      s |= 8'h14;
      else if (a == 8'h08 || a == 8'h09) s |= 8'h08;
      else if (a == 8'h0C || a == 8'h0F) s |= 8'h04;
      else if (a >= 8'h10)               s |= 8'h04;
    end
    return s;
  endfunction

  // driver: one cycle of stimulus; a read pushes its expected value
  task automatic step(input logic w, input logic [7:0] a, input logic o,
                      input logic r, input string tag);
    @(negedge clk);
    wr_en = w; wr_addr = a; fifo_ovf = o; stat_rd = r;
    if (r) sbq.push_back('{model, tag});
    model = (r ? 8'h00 : model) | setbits(w, a, o);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) step(1'b0, 8'h00, 1'b0, 1'b0, "");
  endtask

  task automatic rd(input string tag);
    step(1'b0, 8'h00, 1'b0, 1'b1, tag);
  endtask

  // monitor: compare read data one cycle after a sampled read strobe
  always @(posedge clk) pend <= stat_rd && !rst;

  always @(negedge clk) begin
    if (pend) begin
      if (sbq.size() == 0) begin
        checks++; failures++;
        $display("FAIL R10: unexpected read result actual=0x%02h expected=none", rd_data);
      end else begin
        exp_t e;
        e = sbq.pop_front();
        chk(e.tag, rd_data, e.val);
        last_rd = rd_data;
      end
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 reset rd_data", rd_data, 8'h00);
    rd("R1 reset flags");

    step(1'b0, 8'h00, 1'b1, 1'b0, "");
    rd("R3 fifo overflow");
    rd("R10 cleared after read");

    step(1'b1, 8'h0E, 1'b0, 1'b0, "");
    rd("R4 read-only write");

    step(1'b1, 8'h08, 1'b0, 1'b0, "");
    rd("R5 test write 0x08");
    step(1'b1, 8'h09, 1'b0, 1'b0, "");
    rd("R5 test write 0x09");

    step(1'b1, 8'h0C, 1'b0, 1'b0, "");
    rd("R6 reserved write");
    step(1'b1, 8'h40, 1'b0, 1'b0, "");
    rd("R6 nonexistent write");
    step(1'b1, 8'hFF, 1'b0, 1'b0, "");
    rd("R6 top address");

    step(1'b1, 8'h0D, 1'b0, 1'b0, "");
    rd("R7 status write");

    for (int a = 0; a < 12; a++) begin
      if (a != 8 && a != 9) step(1'b1, 8'(a), 1'b0, 1'b0, "");
    end
    rd("R8 writable writes");

    step(1'b0, 8'h00, 1'b1, 1'b0, "");
    idle(5);
    step(1'b1, 8'h03, 1'b0, 1'b0, "");
    step(1'b1, 8'h0B, 1'b0, 1'b0, "");
    idle(3);
    rd("R9 sticky overflow");

    step(1'b1, 8'h08, 1'b0, 1'b0, "");
    step(1'b0, 8'h00, 1'b1, 1'b1, "R11 same-cycle old value");
    rd("R11 new event kept");

    step(1'b1, 8'h20, 1'b0, 1'b0, "");
    step(1'b1, 8'h0E, 1'b0, 1'b1, "R11 write with read old");
    rd("R11 write kept");

    step(1'b1, 8'h0E, 1'b0, 1'b0, "");
    step(1'b1, 8'h09, 1'b1, 1'b0, "");
    step(1'b1, 8'h0F, 1'b0, 1'b0, "");
    rd("R3 R4 R5 all flags");
    idle(1);
    chk("R2 reserved bits", rd_data & 8'hC3, 8'h00);
    idle(4);
    chk("R10 rd_data holds", rd_data, last_rd);

    step(1'b1, 8'h0E, 1'b1, 1'b0, "");
    step(1'b0, 8'h00, 1'b0, 1'b0, "");
    rst = 1'b1;
    idle(2);
    rst = 1'b0;
    idle(1);
    chk("R1 reset clears rd_data", rd_data, 8'h00);
    model = 8'h00;
    rd("R1 reset clears flags");
    idle(3);

    if (sbq.size() != 0) begin
      checks++; failures++;
      $display("FAIL R10: pending reads actual=%0d expected=0", sbq.size());
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule